// File: doc/BRIEF.md
# Sync-Marker Framed Serial Word Receiver

This block turns an already clock-recovered serial bit stream into 16-bit words. Each incoming bit is qualified by a one-cycle valid strobe, and a carrier level marks the envelope of a packet. While carrier is high the receiver hunts for the first 1 bit. That bit is the sync bit: it fixes the bit phase and is loaded as a marker into a shift register one position wider than a word. Data bits then shift in behind the marker. When the marker reaches the far end, a full word is present. The word goes to a holding register, the marker is recirculated, and the next word starts.

The holding register empties into a 16-entry word buffer whenever the buffer has room. A downstream consumer reads the buffer head and pops it. The service request is raised only while two or more words are buffered. As a result the last word of a packet, which is the received CRC, is never requested on its own.

A CRC-16 is recomputed over every bit after the sync bit, including the appended CRC word. A nonzero remainder at the end of carrier sets a sticky CRC error flag. Two other sticky flags record a packet that ends part-way through a word, and a word lost because the holding register was still occupied. A clear input resets all three flags.

Top module: `syncword_rx`

## Requirements
- R1: After reset the buffer is empty, `svc_req` is 0 and `crc_err`, `short_pkt` and `data_late` are all 0.
- R2: A bit strobed while `carrier` is 0 has no effect, and 0 bits strobed with `carrier` high before the first 1 bit are discarded. The first 1 bit strobed with `carrier` high is the sync bit and is not data.
- R3: Each following group of 16 strobed bits forms one word, and the first bit of the group lands in bit 15. Words leave through `rd_data` (the buffer head) in arrival order, and `pop` advances the head.
- R4: `svc_req` is 1 exactly while the buffer holds two or more words.
- R5: The CRC uses polynomial 0x1021 with initial value 0xFFFF, processes bits in arrival order (most significant bit first) and applies no final inversion. The sender appends the CRC word most significant bit first. When carrier falls after a sync bit and the remainder over all bits after the sync bit is nonzero, `crc_err` is set and stays set.
- R6: When carrier falls after a sync bit while a partial word (1 to 15 bits) is in the shift register, `short_pkt` is set and stays set. A packet that ends on a word boundary leaves it unchanged.
- R7: When a word completes while the holding register is still occupied and cannot move into the buffer, `data_late` is set and stays set. The new word is discarded and the held word is kept.
- R8: The buffer holds 16 words and refuses writes while full. A held word enters the buffer once a pop makes room, and no buffered word is overwritten.
- R9: `clr` set for one cycle clears `crc_err`, `short_pkt` and `data_late`.
- R10: `pop` while the buffer is empty is ignored and leaves the buffer empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Clears the three sticky flags |
| bit_vld | input | 1 | One-cycle strobe qualifying `bit_in` |
| bit_in | input | 1 | Recovered serial data bit |
| carrier | input | 1 | Packet envelope, high while a packet is passing |
| pop | input | 1 | Consume the word at the buffer head |
| rd_data | output | 16 | Word at the buffer head |
| svc_req | output | 1 | Two or more words are buffered |
| crc_err | output | 1 | Sticky: nonzero CRC remainder at packet end |
| short_pkt | output | 1 | Sticky: packet ended inside a word |
| data_late | output | 1 | Sticky: word lost at the holding register |

## Verification
A word whose last bit is strobed at a given edge is in the holding register after that edge and in the buffer after the next one. `svc_req` and `rd_data` therefore reflect it two edges after the strobe, and the bench waits those two edges at the end of every bit before it looks. The end-of-packet flags are set on the edge that first samples carrier low, and a pop moves the head on the edge that samples it. The bench drives every input on the falling edge and reads every output one falling edge after the rising edge that should have changed it, so it never reads a value in the same cycle as it changes.

// File: rtl/swrx_pkg.sv
package swrx_pkg;

   localparam int unsigned SWRX_WORD_W   = 16;
   localparam int unsigned SWRX_DEPTH    = 16;
   localparam int unsigned SWRX_CRC_W    = 16;
   localparam logic [15:0] SWRX_POLY     = 16'h1021;
   localparam logic [15:0] SWRX_CRC_INIT = 16'hFFFF;
   localparam int unsigned SWRX_REQ_LVL  = 2;

   typedef struct packed {
      logic crc_err;
      logic short_pkt;
      logic data_late;
   } swrx_flags_t;

endpackage

// File: rtl/swrx_frame.sv
module swrx_frame #(
   parameter int unsigned W     = 16,
   parameter int unsigned CRC_W = 16,
   parameter logic [CRC_W-1:0] POLY = 16'h1021,
   parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         bit_vld,
   input  logic         bit_in,
   input  logic         carrier,
   output logic         word_done,
   output logic [W-1:0] word,
   output logic         crc_err,
   output logic         short_pkt
);

   localparam logic [W:0] MARK0 = {{W{1'b0}}, 1'b1};

   generate
      if (W < 2) begin : g_bad_w
         $error("swrx_frame: W must be at least 2");
      end
      if (CRC_W < 2) begin : g_bad_crc
         $error("swrx_frame: CRC_W must be at least 2");
      end
   endgenerate

   logic [W:0]       sr_q;
   logic [W:0]       sr_nxt;
   logic             active_q;
   logic             car_q;
   logic             car_fall;
   logic             take;
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_nxt;
   logic             fb;

   assign car_fall  = car_q & ~carrier;
   assign take      = bit_vld & carrier;
   assign sr_nxt    = {sr_q[W-1:0], bit_in};
   assign word_done = take & active_q & sr_nxt[W];
   assign word      = sr_nxt[W-1:0];

   // serial CRC step, one tap per polynomial bit
   assign fb = crc_q[CRC_W-1] ^ bit_in;
   generate
      for (genvar i = 0; i < CRC_W; i++) begin : g_crc
         if (i == 0) begin : g_lsb
            assign crc_nxt[i] = fb & POLY[i];
         end else begin : g_up
            assign crc_nxt[i] = crc_q[i-1] ^ (fb & POLY[i]);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q     <= '0;
         active_q <= 1'b0;
         car_q    <= 1'b0;
         crc_q    <= INIT;
      end else begin
         car_q <= carrier;
         if (car_fall) begin
            sr_q     <= '0;
            active_q <= 1'b0;
         end else if (take) begin
            if (!active_q) begin
               if (bit_in) begin
                  active_q <= 1'b1;
                  sr_q     <= MARK0;
                  crc_q    <= INIT;
               end
            end else begin
               crc_q <= crc_nxt;
               if (sr_nxt[W]) begin
                  sr_q <= MARK0;
               end else begin
                  sr_q <= sr_nxt;
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_err   <= 1'b0;
         short_pkt <= 1'b0;
      end else if (clr) begin
         crc_err   <= 1'b0;
         short_pkt <= 1'b0;
      end else if (car_fall && active_q) begin
         if (sr_q != MARK0) short_pkt <= 1'b1;
         if (crc_q != '0)   crc_err   <= 1'b1;
      end
   end

   // R2: outside a packet the shift register holds nothing
   a_r2_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> (sr_q == '0));

   // R6: a drop inside a word records a short packet
   a_r6_short: assert property (@(posedge clk) disable iff (!rst_n)
      (car_fall && active_q && (sr_q != MARK0) && !clr) |=> short_pkt);

   // R5: a nonzero remainder at packet end records a CRC error
   a_r5_crc_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (car_fall && active_q && (crc_q != '0) && !clr) |=> crc_err);

   // R9: clear empties both flags
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!crc_err && !short_pkt));

endmodule

// File: rtl/swrx_hold.sv
module swrx_hold #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         word_done,
   input  logic [W-1:0] word,
   input  logic         full,
   output logic         push,
   output logic [W-1:0] push_data,
   output logic         data_late
);

   generate
      if (W < 1) begin : g_bad_w
         $error("swrx_hold: W must be positive");
      end
   endgenerate

   logic         hold_vld;
   logic [W-1:0] hold_q;

   assign push      = hold_vld & ~full;
   assign push_data = hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_vld <= 1'b0;
         hold_q   <= '0;
      end else if (word_done && (!hold_vld || push)) begin
         hold_vld <= 1'b1;
         hold_q   <= word;
      end else if (push) begin
         hold_vld <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_late <= 1'b0;
      end else if (clr) begin
         data_late <= 1'b0;
      end else if (word_done && hold_vld && !push) begin
         data_late <= 1'b1;
      end
   end

   // R7: a word arriving on a stuck holding register is recorded as late
   a_r7_late: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && hold_vld && !push && !clr) |=> data_late);

   // R7: the held word survives a late arrival
   a_r7_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && hold_vld && !push) |=> (hold_vld && $stable(hold_q)));

endmodule

// File: rtl/swrx_fifo.sv
module swrx_fifo #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic [$clog2(DEPTH):0]     count,
   output logic                       full
);

   localparam int unsigned AW = $clog2(DEPTH);
   localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("swrx_fifo: DEPTH must be at least 2");
      end
      if ((1 << AW) != DEPTH) begin : g_bad_pow2
         $error("swrx_fifo: DEPTH must be a power of two");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp;
   logic [AW-1:0] rp;
   logic          do_push;
   logic          do_pop;

   assign full    = (count == CAP);
   assign do_push = push & ~full;
   assign do_pop  = pop & (count != '0);
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R8: nothing is offered while the buffer is full
   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);

   // R10: popping an empty buffer leaves it empty
   a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      ((count == '0) && pop && !push) |=> (count == '0));

endmodule

// File: rtl/syncword_rx.sv
module syncword_rx
   import swrx_pkg::*;
#(
   parameter int unsigned WORD_W = SWRX_WORD_W,
   parameter int unsigned DEPTH  = SWRX_DEPTH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              bit_vld,
   input  logic              bit_in,
   input  logic              carrier,
   input  logic              pop,
   output logic [WORD_W-1:0] rd_data,
   output logic              svc_req,
   output logic              crc_err,
   output logic              short_pkt,
   output logic              data_late
);

   localparam int unsigned CW = $clog2(DEPTH) + 1;
   localparam logic [CW-1:0] REQ = CW'(SWRX_REQ_LVL);

   generate
      if (WORD_W != SWRX_CRC_W) begin : g_bad_word
         $error("syncword_rx: WORD_W must match the CRC width");
      end
      if (DEPTH < SWRX_REQ_LVL) begin : g_bad_depth
         $error("syncword_rx: DEPTH below request level");
      end
   endgenerate

   logic              word_done;
   logic [WORD_W-1:0] word;
   logic              push;
   logic [WORD_W-1:0] push_data;
   logic              full;
   logic [CW-1:0]     fifo_cnt;
   swrx_flags_t       flags;

   swrx_frame #(
      .W     (WORD_W),
      .CRC_W (SWRX_CRC_W),
      .POLY  (SWRX_POLY),
      .INIT  (SWRX_CRC_INIT)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .bit_vld   (bit_vld),
      .bit_in    (bit_in),
      .carrier   (carrier),
      .word_done (word_done),
      .word      (word),
      .crc_err   (flags.crc_err),
      .short_pkt (flags.short_pkt)
   );

   swrx_hold #(
      .W (WORD_W)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .word_done (word_done),
      .word      (word),
      .full      (full),
      .push      (push),
      .push_data (push_data),
      .data_late (flags.data_late)
   );

   swrx_fifo #(
      .W     (WORD_W),
      .DEPTH (DEPTH)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   (push_data),
      .pop   (pop),
      .dout  (rd_data),
      .count (fifo_cnt),
      .full  (full)
   );

   assign svc_req   = (fifo_cnt >= REQ);
   assign crc_err   = flags.crc_err;
   assign short_pkt = flags.short_pkt;
   assign data_late = flags.data_late;

   // R4: the request rises only as the second word arrives
   a_r4_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(svc_req) |-> ($past(fifo_cnt) == CW'(1)));

   // R4: the request falls only as the buffer drops to one word
   a_r4_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(svc_req) |-> (fifo_cnt == CW'(1)));

endmodule

// File: tb/sim_syncword_rx.sv
module sim_syncword_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        bit_vld = 1'b0;
   logic        bit_in = 1'b0;
   logic        carrier = 1'b0;
   logic        pop = 1'b0;
   logic [15:0] rd_data;
   logic        svc_req;
   logic        crc_err;
   logic        short_pkt;
   logic        data_late;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   syncword_rx u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .bit_vld   (bit_vld),
      .bit_in    (bit_in),
      .carrier   (carrier),
      .pop       (pop),
      .rd_data   (rd_data),
      .svc_req   (svc_req),
      .crc_err   (crc_err),
      .short_pkt (short_pkt),
      .data_late (data_late)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_of(input logic [15:0] w [], input int n);
      logic [15:0] c = 16'hFFFF;
      for (int k = 0; k < n; k++) begin
         for (int b = 15; b >= 0; b--) begin
            logic f = c[15] ^ w[k][b];
            c = {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
         end
      end
      return c;
   endfunction

   task automatic send_bit(input logic b);
      bit_vld = 1'b1;
      bit_in  = b;
      tick();
      bit_vld = 1'b0;
      tick();
   endtask

   task automatic send_word(input logic [15:0] w);
      for (int b = 15; b >= 0; b--) send_bit(w[b]);
   endtask

   task automatic start_pkt();
      carrier = 1'b1;
      tick();
      send_bit(1'b0);
      send_bit(1'b0);
      send_bit(1'b1);
   endtask

   task automatic end_pkt();
      carrier = 1'b0;
      tick();
      tick();
   endtask

   task automatic pop_chk(input string req, input logic [15:0] exp);
      chk(req, rd_data, exp);
      pop = 1'b1;
      tick();
      pop = 1'b0;
   endtask

   task automatic do_clr();
      clr = 1'b1;
      tick();
      clr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 svc_req", svc_req, 0);
      chk("R1 crc_err", crc_err, 0);
      chk("R1 short_pkt", short_pkt, 0);
      chk("R1 data_late", data_late, 0);
   endtask

   task automatic t_empty_pop_and_noise();
      pop = 1'b1;
      tick();
      pop = 1'b0;
      tick();
      chk("R10 svc_req after empty pop", svc_req, 0);
      // 1 bits without carrier must not start a packet (R2)
      for (int k = 0; k < 5; k++) send_bit(1'b1);
      tick();
   endtask

   task automatic t_good_packet();
      logic [15:0] w [] = new[3];
      logic [15:0] c;
      w[0] = 16'hA5C3; w[1] = 16'h0001; w[2] = 16'h8000;
      c = crc_of(w, 3);
      start_pkt();
      send_word(w[0]);
      chk("R4 one word no request", svc_req, 0);
      send_word(w[1]);
      chk("R4 two words request", svc_req, 1);
      send_word(w[2]);
      send_word(c);
      end_pkt();
      chk("R5 good crc", crc_err, 0);
      chk("R6 boundary end", short_pkt, 0);
      pop_chk("R3 word0 R2 sync stripped", w[0]);
      pop_chk("R3 word1", w[1]);
      chk("R4 two left", svc_req, 1);
      pop_chk("R3 word2", w[2]);
      chk("R4 crc word withheld", svc_req, 0);
      pop_chk("R5 crc word at head", c);
      pop_chk("R10 empty pop tolerated", rd_data);
      tick();
      chk("R10 stays idle", svc_req, 0);
   endtask

   task automatic t_bad_crc();
      logic [15:0] w [] = new[2];
      logic [15:0] c;
      w[0] = 16'h1234; w[1] = 16'hFEDC;
      c = crc_of(w, 2) ^ 16'h0100;
      start_pkt();
      send_word(w[0]);
      send_word(w[1]);
      send_word(c);
      end_pkt();
      chk("R5 crc error set", crc_err, 1);
      chk("R6 no short", short_pkt, 0);
      tick(); tick();
      chk("R5 crc error sticky", crc_err, 1);
      pop_chk("R3 word0", w[0]);
      pop_chk("R3 word1", w[1]);
      pop_chk("R3 crc word", c);
      do_clr();
      chk("R9 crc error cleared", crc_err, 0);
   endtask

   task automatic t_short();
      start_pkt();
      send_word(16'h5A5A);
      for (int k = 0; k < 5; k++) send_bit(1'b1);
      end_pkt();
      chk("R6 short packet", short_pkt, 1);
      chk("R7 no late", data_late, 0);
      chk("R6 partial not buffered", svc_req, 0);
      pop_chk("R3 whole word kept", 16'h5A5A);
      do_clr();
      chk("R9 short cleared", short_pkt, 0);
      chk("R9 crc cleared", crc_err, 0);
   endtask

   task automatic t_overrun();
      start_pkt();
      for (int k = 0; k < 18; k++) begin
         send_word(16'h1000 + 16'(k));
         if (k == 16) chk("R7 no late while hold free", data_late, 0);
      end
      end_pkt();
      chk("R7 late set", data_late, 1);
      chk("R8 full request", svc_req, 1);
      for (int k = 0; k < 17; k++) pop_chk("R8 R7 order kept", 16'h1000 + 16'(k));
      tick();
      chk("R8 extra word discarded", svc_req, 0);
      chk("R7 late sticky", data_late, 1);
      do_clr();
      chk("R9 late cleared", data_late, 0);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      tick();
      tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_empty_pop_and_noise();
      t_good_packet();
      t_bad_crc();
      t_short();
      t_overrun();
      done = 1'b1;
      finish_run();
   end

endmodule